// File: doc/BRIEF.md
# Two-Stage Timebase Watchdog

A memory-mapped watchdog that escalates in two steps. A free-running 32-bit timebase counter runs from bus reset. Each time its low `INTV_W` bits roll over from all ones to zero while the watchdog is armed, that counts as an expiry. The first unserviced expiry raises a state flag and sends a one-cycle interrupt. Software can use that interrupt to recover. If the state flag is still set at the next expiry, the block drives a system reset pulse and latches a reset-status flag.

Software arms the watchdog through two enable bits, one in each control register. Either bit alone keeps it armed, so one stray write cannot disarm it. Software services the watchdog by writing ones to the state and reset-status bits, which clears them. It can also read the timebase to confirm that the clock is running. The bus port is a plain single-cycle interface: one address, a write strobe, write data, and read data driven combinationally.

Top module: `wdog_twostage`

## Requirements
- R1: On bus reset the timebase, both enable bits, both flags, the interrupt and the system reset output are all zero.
- R2: The timebase at byte address 0x8 increments by one on every clock. Writes to that address do not change it.
- R3: Enable A is bit 1 of the register at 0x0, and enable B is bit 0 of the register at 0x4. Expiries count while either bit is 1. With both bits 0, expiries are ignored and neither flag changes.
- R4: An expiry is a clock edge at which the low `INTV_W` timebase bits are all ones while armed. If the state flag is clear at that edge, the expiry sets the flag and drives `irq_pulse` high for exactly the following cycle.
- R5: An expiry with the state flag already set drives `sys_reset` high for `RST_HOLD` cycles and sets the reset-status flag. An interrupt and the reset that follows it are therefore exactly 2^`INTV_W` cycles apart.
- R6: In the register at 0x0, writing 1 to bit 2 clears the state flag and writing 1 to bit 3 clears the reset-status flag. Writing 0 to either bit leaves it unchanged. A write that clears the state flag in the same cycle as an expiry cancels that expiry.
- R7: The reset-status flag stays set after `sys_reset` ends. Only a write-one clear or bus reset removes it. Driving `sys_reset` does not clear the state flag.
- R8: Reading 0x0 returns the reset-status flag in bit 3, the state flag in bit 2, enable A in bit 1, and zero elsewhere. Reading 0x4 returns enable B in bit 0 and zero elsewhere. Every other address reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Bus reset, active low, asynchronous |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_pulse | output | 1 | One-cycle interrupt on first-stage expiry |
| sys_reset | output | 1 | System reset, high for RST_HOLD cycles on second-stage expiry |

## Verification
A state flag that is set or cleared wrongly shows up within one timebase interval. Either an interrupt appears where a reset was due, or a reset appears one interval early, and register 0x0 reads back the wrong value at once. A timebase that skips or stalls shifts the 2^`INTV_W` spacing between interrupt and reset, and consecutive reads show a step other than one. A faulty hold counter changes the measured width of the reset pulse.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  localparam int unsigned DATA_W = 32;

  // Byte offsets of the three registers
  localparam int unsigned OFS_CTRL_A = 0;
  localparam int unsigned OFS_CTRL_B = 4;
  localparam int unsigned OFS_TBASE  = 8;

  // Bit positions that software decodes
  localparam int unsigned BIT_RST_ST = 3;
  localparam int unsigned BIT_STATE  = 2;
  localparam int unsigned BIT_EN_A   = 1;
  localparam int unsigned BIT_EN_B   = 0;

  // True when the lowest n bits of v are all ones (next increment rolls over)
  function automatic logic window_full(input logic [31:0] v, input int unsigned n);
    logic all_set;
    all_set = 1'b1;
    for (int i = 0; i < 32; i++) begin
      if (i < n && !v[i]) all_set = 1'b0;
    end
    return all_set;
  endfunction

  // Read image of control register A
  function automatic logic [DATA_W-1:0] pack_ctrl_a(input logic rst_st,
                                                    input logic state,
                                                    input logic en_a);
    logic [DATA_W-1:0] img;
    img = '0;
    img[BIT_RST_ST] = rst_st;
    img[BIT_STATE]  = state;
    img[BIT_EN_A]   = en_a;
    return img;
  endfunction

endpackage

// File: rtl/wdt_timebase.sv
module wdt_timebase #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned INTV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [CNT_W-1:0] count,
  output logic             wrap_due
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(1);
  end

  assign wrap_due = wdt_pkg::window_full(32'(count), INTV_W);

  assert_tb_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> count == $past(count) + CNT_W'(1));

endmodule

// File: rtl/wdt_regs.sv
module wdt_regs #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic                       we,
  input  logic [wdt_pkg::DATA_W-1:0] wdata,
  input  logic                       state_flag,
  input  logic                       rst_flag,
  input  logic [CNT_W-1:0]           tb_count,
  output logic                       armed,
  output logic                       clr_state,
  output logic                       clr_rst,
  output logic [wdt_pkg::DATA_W-1:0] rdata
);
  import wdt_pkg::*;

  logic sel_a, sel_b, sel_t;
  logic en_a, en_b;

  assign sel_a = (addr == ADDR_W'(OFS_CTRL_A));
  assign sel_b = (addr == ADDR_W'(OFS_CTRL_B));
  assign sel_t = (addr == ADDR_W'(OFS_TBASE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_a <= 1'b0;
      en_b <= 1'b0;
    end else if (we) begin
      if (sel_a) en_a <= wdata[BIT_EN_A];
      if (sel_b) en_b <= wdata[BIT_EN_B];
    end
  end

  assign armed     = en_a | en_b;
  assign clr_state = we & sel_a & wdata[BIT_STATE];
  assign clr_rst   = we & sel_a & wdata[BIT_RST_ST];

  always_comb begin
    rdata = '0;
    if (sel_a)      rdata = pack_ctrl_a(rst_flag, state_flag, en_a);
    else if (sel_b) rdata[BIT_EN_B] = en_b;
    else if (sel_t) rdata = DATA_W'(tb_count);
  end

  // Arming changes only through a write to one of the control registers
  assert_arm_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(we && (sel_a || sel_b)) |=> $stable(armed));

endmodule

// File: rtl/wdt_stage_fsm.sv
module wdt_stage_fsm #(
  parameter int unsigned RST_HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic wrap_due,
  input  logic clr_state,
  input  logic clr_rst,
  output logic state_flag,
  output logic rst_flag,
  output logic irq_pulse,
  output logic sys_reset,
  output logic stage1_hit,
  output logic stage2_hit
);
  localparam int unsigned HOLD_W = $clog2(RST_HOLD + 1);

  logic              expire;
  logic [HOLD_W-1:0] hold_cnt;

  // A service write in the same cycle cancels the expiry
  assign expire     = armed & wrap_due & ~clr_state;
  assign stage1_hit = expire & ~state_flag;
  assign stage2_hit = expire & state_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_flag <= 1'b0;
      rst_flag   <= 1'b0;
      irq_pulse  <= 1'b0;
      hold_cnt   <= '0;
    end else begin
      if (clr_state)       state_flag <= 1'b0;
      else if (stage1_hit) state_flag <= 1'b1;

      if (stage2_hit)   rst_flag <= 1'b1;
      else if (clr_rst) rst_flag <= 1'b0;

      irq_pulse <= stage1_hit;

      if (stage2_hit)          hold_cnt <= HOLD_W'(RST_HOLD);
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - HOLD_W'(1);
    end
  end

  assign sys_reset = (hold_cnt != '0);

  assert_irq_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |=> !irq_pulse);

  assert_irq_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pulse) |-> $past(armed && wrap_due) && state_flag);

  assert_reset_needs_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_reset) |-> $past(state_flag) && rst_flag);

  assert_disarmed_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !armed && !clr_state |=> $stable(state_flag));

  assert_rstflag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_flag && !clr_rst |=> rst_flag);

endmodule

// File: rtl/wdog_twostage.sv
module wdog_twostage #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned CNT_W    = 32,
  parameter int unsigned INTV_W   = 8,
  parameter int unsigned RST_HOLD = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_pulse,
  output logic              sys_reset
);

  logic [CNT_W-1:0] tb_count;
  logic             wrap_due;
  logic             armed, clr_state, clr_rst;
  logic             state_flag, rst_flag;
  logic             stage1_hit, stage2_hit;

  wdt_timebase #(.CNT_W(CNT_W), .INTV_W(INTV_W)) u_tbase (
    .clk      (clk),
    .rst_n    (rst_n),
    .count    (tb_count),
    .wrap_due (wrap_due)
  );

  wdt_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr       (bus_addr),
    .we         (bus_we),
    .wdata      (bus_wdata),
    .state_flag (state_flag),
    .rst_flag   (rst_flag),
    .tb_count   (tb_count),
    .armed      (armed),
    .clr_state  (clr_state),
    .clr_rst    (clr_rst),
    .rdata      (bus_rdata)
  );

  wdt_stage_fsm #(.RST_HOLD(RST_HOLD)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .armed      (armed),
    .wrap_due   (wrap_due),
    .clr_state  (clr_state),
    .clr_rst    (clr_rst),
    .state_flag (state_flag),
    .rst_flag   (rst_flag),
    .irq_pulse  (irq_pulse),
    .sys_reset  (sys_reset),
    .stage1_hit (stage1_hit),
    .stage2_hit (stage2_hit)
  );

  assert_stages_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(stage1_hit && stage2_hit));

  assert_reset_after_irq_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stage2_hit |-> state_flag && !irq_pulse);

endmodule

// File: tb/wdog_twostage_tb.sv
`timescale 1ns/1ps
module wdog_twostage_tb;
  localparam int unsigned N  = 4;
  localparam int unsigned RH = 5;
  localparam int unsigned IV = 1 << N;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, srst;

  int n_checks = 0;
  int n_err = 0;

  always #10 clk = ~clk;

  wdog_twostage #(.ADDR_W(4), .CNT_W(32), .INTV_W(N), .RST_HOLD(RH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_pulse(irq), .sys_reset(srst)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Spec model, written from the requirements
  logic [31:0] m_tb;
  logic        m_en_a, m_en_b, m_state, m_rst, m_irq;
  int          m_hold;
  logic        m_wa, m_exp;
  assign m_wa  = we && (addr == 4'h0);
  assign m_exp = (m_en_a || m_en_b) && (m_tb[N-1:0] == {N{1'b1}}) && !(m_wa && wdata[2]);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tb <= '0; m_en_a <= 1'b0; m_en_b <= 1'b0;
      m_state <= 1'b0; m_rst <= 1'b0; m_irq <= 1'b0; m_hold <= 0;
    end else begin
      m_tb <= m_tb + 1;
      if (m_wa) m_en_a <= wdata[1];
      if (we && addr == 4'h4) m_en_b <= wdata[0];
      if (m_wa && wdata[2]) m_state <= 1'b0;
      else if (m_exp && !m_state) m_state <= 1'b1;
      if (m_exp && m_state) m_rst <= 1'b1;
      else if (m_wa && wdata[3]) m_rst <= 1'b0;
      m_irq <= m_exp && !m_state;
      m_hold <= (m_exp && m_state) ? RH : ((m_hold > 0) ? m_hold - 1 : 0);
    end
  end

  function automatic logic [31:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0:    return {28'b0, m_rst, m_state, m_en_a, 1'b0};
      4'h4:    return {31'b0, m_en_b};
      4'h8:    return m_tb;
      default: return 32'b0;
    endcase
  endfunction

  // Per-cycle comparison and event bookkeeping, away from the clock edge
  int  cyc = 0, irq_cnt = 0, irq_cyc = 0, rise_cnt = 0, rise_cyc = 0;
  int  run_len = 0, last_len = 0;
  logic srst_d = 1'b0;
  always @(posedge clk) begin
    #5;
    cyc++;
    if (rst_n) begin
      check(irq == m_irq, "R4 irq_pulse", 32'(irq), 32'(m_irq));
      check(srst == (m_hold > 0), "R5 sys_reset", 32'(srst), 32'(m_hold > 0));
      check(rdata == exp_read(addr), "R8 read data", rdata, exp_read(addr));
      if (irq) begin irq_cnt++; irq_cyc = cyc; end
      if (srst && !srst_d) begin rise_cnt++; rise_cyc = cyc; end
      if (srst) run_len++;
      else if (srst_d) begin last_len = run_len; run_len = 0; end
    end
    srst_d = srst;
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; we = 1'b1; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; we = 1'b0; #1 v = rdata;
  endtask

  task automatic wait_rise(input int target);
    for (int i = 0; i < 400 && rise_cnt < target; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] v, t0;
    int irq0, rise0;
    addr = 4'h8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rdata == 0, "R1 timebase after reset", rdata, 0);
    check(irq == 0 && srst == 0, "R1 outputs after reset", {irq, srst}, 0);
    rd(4'h0, v); check(v == 0, "R1 reg A after reset", v, 0);
    rd(4'h4, v); check(v == 0, "R1 reg B after reset", v, 0);

    // Disarmed: many rollovers, no events
    repeat (3 * IV) @(negedge clk);
    check(irq_cnt == 0 && rise_cnt == 0, "R3 disarmed no events", irq_cnt + rise_cnt, 0);

    // Timebase step and write-ignore
    rd(4'h8, t0);
    @(negedge clk); #1 v = rdata;
    check(v == t0 + 1, "R2 timebase step", v, t0 + 1);
    @(negedge clk); t0 = rdata; we = 1'b1; wdata = 32'hFFFF_0000;
    @(negedge clk); we = 1'b0; #1 v = rdata;
    check(v == t0 + 1, "R2 timebase write ignored", v, t0 + 1);

    // Arm with enable A only, let both stages fire
    wr(4'h0, 32'h2);
    wait_rise(1);
    check(rise_cnt == 1, "R5 reset fired", rise_cnt, 1);
    check(rise_cyc - irq_cyc == IV, "R5 irq to reset spacing", rise_cyc - irq_cyc, IV);
    repeat (RH + 2) @(negedge clk);
    check(last_len == RH, "R5 reset width", last_len, RH);
    rd(4'h0, v); check(v == 32'hE, "R7 flags survive reset", v, 32'hE);
    wr(4'h0, 32'h2);
    rd(4'h0, v); check(v[3:2] == 2'b11, "R6 write zero no effect", v, 32'hE);
    wr(4'h0, 32'hE);
    rd(4'h0, v); check(v[3:2] == 2'b00, "R6 write one clears", v, 32'h2);

    // Keepalive at every phase of the interval: never a reset
    rise0 = rise_cnt;
    for (int p = 0; p < IV + 2; p++) begin
      wr(4'h0, 32'h6);
      repeat (p % (IV - 3)) @(negedge clk);
    end
    check(rise_cnt == rise0, "R6 serviced no reset", rise_cnt, rise0);

    // Arm with enable B only
    wr(4'h0, 32'h4);
    wr(4'h4, 32'h1);
    wait_rise(rise0 + 1);
    check(rise_cnt == rise0 + 1, "R3 enable B arms", rise_cnt, rise0 + 1);
    rd(4'h0, v); check(v[1] == 1'b0 && v[3] == 1'b1, "R8 reg A image", v, 32'hC);

    // Disarm both: no further events, flags frozen
    wr(4'h4, 32'h0);
    wr(4'h0, 32'h8);
    irq0 = irq_cnt; rise0 = rise_cnt;
    repeat (3 * IV) @(negedge clk);
    check(irq_cnt == irq0 && rise_cnt == rise0, "R3 disarmed after stop",
          irq_cnt + rise_cnt, irq0 + rise0);
    rd(4'h0, v); check(v == 32'h4, "R3 state flag frozen", v, 32'h4);
    rd(4'hC, v); check(v == 0, "R8 unused address", v, 0);

    // Bus reset clears the sticky flag
    wr(4'h0, 32'h2);
    wait_rise(rise0 + 1);
    rd(4'h0, v); check(v[3] == 1'b1, "R7 reset status set", v, 32'h8);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; addr = 4'h0; #1;
    check(rdata == 0, "R1 bus reset clears flags", rdata, 0);
    check(srst == 0, "R1 bus reset clears sys_reset", 32'(srst), 0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_err++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", cyc, 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

endmodule